// File: doc/BRIEF.md
# Coherence Upgrade/Downgrade Balance Checker

This block watches a set of caching nodes and confirms, once per logical-time epoch, that every permission increase on a block is matched by permission decreases elsewhere in the system. Each node keeps a signed, address-weighted running total. Raising permission on a block adds the block address to the total once for each permission level crossed. Lowering permission subtracts it the same way. A balanced epoch therefore leaves the system-wide total at zero.

A shared counter counts broadcast coherence requests. When the epoch-closing request arrives, every node hands its total to a central adder and starts the next epoch from zero in the same cycle. The adder forms the sum modulo 2^W. It flags an error when that sum is non-zero, so that a recovery mechanism elsewhere can act on it. A single upgrade may be answered by several downgrades spread across different nodes, and the per-level weighting lets those downgrades cancel the upgrade with no node knowing how many others took part.

Top module: `pbal_checker`

## Requirements
- R1: Permission codes are 2 bits: 0 = none, 1 = read, 2 = write. An event with new > old is an upgrade and adds the address to its node's total once per level crossed, so none-to-write adds it twice.
- R2: An event with new < old is a downgrade and subtracts the address once per level crossed, so write-to-none subtracts it twice.
- R3: An event whose old and new codes are equal has no effect. An event that uses the reserved code 3 on either side also has no effect, and neither does a node whose strobe is low.
- R4: An epoch closes on every PERIOD-th `req_tick` pulse counted since reset. `chk_valid` is high for exactly the one cycle after each closing edge and low otherwise.
- R5: At a close, `chk_sum` takes the sum, modulo 2^W, of all node totals accumulated during the closing epoch. `chk_error` is set when that sum is non-zero. Both hold until the next close.
- R6: At a close, every node total restarts at zero. An event presented in the closing cycle is counted in the new epoch and not in the closing one.
- R7: All totals and the system sum wrap modulo 2^W, so an epoch whose contributions sum to a multiple of 2^W reports no error.
- R8: After reset, `chk_valid`, `chk_error` and `chk_sum` are zero, the node totals are zero and the request count starts from zero. Reset is taken asynchronously and released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_tick | input | 1 | One pulse per broadcast coherence request (logical time) |
| evt_vld | input | N | Per-node permission-change strobe |
| evt_old | input | 2*N | Per-node previous permission code, node i at bits [2i+1:2i] |
| evt_new | input | 2*N | Per-node new permission code, node i at bits [2i+1:2i] |
| evt_addr | input | W*N | Per-node block address, node i at bits [W*i+W-1:W*i] |
| chk_valid | output | 1 | One-cycle pulse after each epoch close |
| chk_error | output | 1 | Imbalance flag from the latest close |
| chk_sum | output | W | System sum from the latest close |

## Verification
Every fault in a node total stays hidden until the next epoch close, at most PERIOD request pulses later. It then shows up as a wrong `chk_sum`, and usually as a wrong `chk_error`. A request counter that has drifted shifts the `chk_valid` pulse by one or more cycles, and that shift can be seen at the very next close. Mis-weighting a two-level change, or letting a closing-cycle event leak into the wrong epoch, leaves `chk_sum` off by exactly one multiple of the address. The bench therefore compares the full sum at every close, not just the flag.

// File: rtl/pbal_pkg.sv
package pbal_pkg;

  typedef enum logic [1:0] {
    PERM_NONE  = 2'd0,
    PERM_READ  = 2'd1,
    PERM_WRITE = 2'd2,
    PERM_RSVD  = 2'd3
  } perm_e;

  // Signed level difference new - old; zero when either code is reserved.
  function automatic logic signed [2:0] perm_steps(input logic [1:0] old_p,
                                                   input logic [1:0] new_p);
    logic signed [2:0] d;
    if (old_p == PERM_RSVD || new_p == PERM_RSVD) begin
      d = 3'sd0;
    end else begin
      d = $signed({1'b0, new_p}) - $signed({1'b0, old_p});
    end
    return d;
  endfunction

endpackage

// File: rtl/pbal_epoch_ctr.sv
module pbal_epoch_ctr #(
  parameter int PERIOD = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tick,
  output logic epoch_end
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    epoch_end = req_tick && (cnt_q == CW'(PERIOD - 1));
    cnt_en    = req_tick;
    cnt_d     = epoch_end ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(PERIOD));

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_tick |=> $stable(cnt_q));

endmodule

// File: rtl/pbal_node_acc.sv
module pbal_node_acc
  import pbal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_vld,
  input  logic [1:0]   old_perm,
  input  logic [1:0]   new_perm,
  input  logic [W-1:0] addr,
  input  logic         epoch_end,
  output logic [W-1:0] acc
);
  logic [W-1:0]      acc_q, acc_d, delta;
  logic signed [2:0] steps;
  logic [W-1:0]      addr_x2;

  always_comb begin
    steps   = evt_vld ? perm_steps(old_perm, new_perm) : 3'sd0;
    addr_x2 = {addr[W-2:0], 1'b0};
    case (steps)
      3'sd1:   delta = addr;
      3'sd2:   delta = addr_x2;
      -3'sd1:  delta = '0 - addr;
      -3'sd2:  delta = '0 - addr_x2;
      default: delta = '0;
    endcase
    acc_d = (epoch_end ? '0 : acc_q) + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!epoch_end && (!evt_vld || old_perm == new_perm)) |=> $stable(acc_q));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_end && !evt_vld) |=> (acc_q == '0));

  p_up_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!epoch_end && evt_vld && old_perm == PERM_NONE && new_perm == PERM_READ)
    |=> (acc_q == $past(acc_q) + $past(addr)));

  p_dn_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!epoch_end && evt_vld && old_perm == PERM_WRITE && new_perm == PERM_READ)
    |=> (acc_q == $past(acc_q) - $past(addr)));

endmodule

// File: rtl/pbal_sum_check.sv
module pbal_sum_check #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] node_acc,
  input  logic           epoch_end,
  output logic           chk_valid,
  output logic           chk_error,
  output logic [W-1:0]   chk_sum
);
  logic [W-1:0] total;
  logic [W-1:0] sum_q;
  logic         err_q, vld_q;

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + node_acc[W*i +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      err_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= epoch_end;
      if (epoch_end) begin
        sum_q <= total;
        err_q <= (total != '0);
      end
    end
  end

  assign chk_valid = vld_q;
  assign chk_error = err_q;
  assign chk_sum   = sum_q;

  p_err_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_error |-> (chk_sum != '0));

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_end |=> !chk_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_end |=> ($stable(chk_sum) && $stable(chk_error)));

endmodule

// File: rtl/pbal_checker.sv
module pbal_checker #(
  parameter int N      = 4,
  parameter int W      = 16,
  parameter int PERIOD = 3000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_tick,
  input  logic [N-1:0]   evt_vld,
  input  logic [2*N-1:0] evt_old,
  input  logic [2*N-1:0] evt_new,
  input  logic [W*N-1:0] evt_addr,
  output logic           chk_valid,
  output logic           chk_error,
  output logic [W-1:0]   chk_sum
);
  logic [1:0]     rst_pipe;
  logic           rst_s_n;
  logic           epoch_end;
  logic [N*W-1:0] node_acc;

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  pbal_epoch_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .req_tick  (req_tick),
    .epoch_end (epoch_end)
  );

  for (genvar g = 0; g < N; g++) begin : g_node
    pbal_node_acc #(.W(W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .evt_vld   (evt_vld[g]),
      .old_perm  (evt_old[2*g +: 2]),
      .new_perm  (evt_new[2*g +: 2]),
      .addr      (evt_addr[W*g +: W]),
      .epoch_end (epoch_end),
      .acc       (node_acc[W*g +: W])
    );
  end

  pbal_sum_check #(.N(N), .W(W)) u_sum (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .node_acc  (node_acc),
    .epoch_end (epoch_end),
    .chk_valid (chk_valid),
    .chk_error (chk_error),
    .chk_sum   (chk_sum)
  );

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (!chk_valid && !chk_error && chk_sum == '0));

endmodule

// File: tb/pbal_checker_test.sv
module pbal_checker_test;
  localparam int N = 4;
  localparam int W = 16;
  localparam int PERIOD = 10;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_tick;
  logic [N-1:0]   evt_vld;
  logic [2*N-1:0] evt_old, evt_new;
  logic [W*N-1:0] evt_addr;
  logic           chk_valid, chk_error;
  logic [W-1:0]   chk_sum;

  int checks = 0;
  int errors = 0;
  int mcnt = 0;
  logic [W-1:0] macc [N];
  logic         e_vld, e_err;
  logic [W-1:0] e_sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbal_checker #(.N(N), .W(W), .PERIOD(PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .req_tick(req_tick), .evt_vld(evt_vld),
    .evt_old(evt_old), .evt_new(evt_new), .evt_addr(evt_addr),
    .chk_valid(chk_valid), .chk_error(chk_error), .chk_sum(chk_sum)
  );

  function automatic logic [W-1:0] weight(input logic [1:0] o, input logic [1:0] n,
                                          input logic [W-1:0] a);
    int lv;
    logic [W-1:0] r;
    if (o == 2'd3 || n == 2'd3) return '0;
    lv = int'(n) - int'(o);
    r = '0;
    if (lv > 0) for (int k = 0; k < lv; k++) r = r + a;
    if (lv < 0) for (int k = 0; k < -lv; k++) r = r - a;
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    req_tick = 0; evt_vld = '0; evt_old = '0; evt_new = '0; evt_addr = '0;
  endtask

  // Inputs already driven; update model, clock once, check at the falling edge.
  task automatic step();
    logic bnd;
    logic [W-1:0] s;
    bnd = req_tick && (mcnt == PERIOD - 1);
    if (req_tick) mcnt = bnd ? 0 : mcnt + 1;
    if (bnd) begin
      s = '0;
      for (int i = 0; i < N; i++) s = s + macc[i];
      e_sum = s; e_err = (s != '0);
      for (int i = 0; i < N; i++) macc[i] = '0;
    end
    e_vld = bnd;
    for (int i = 0; i < N; i++)
      if (evt_vld[i])
        macc[i] = macc[i] + weight(evt_old[2*i +: 2], evt_new[2*i +: 2], evt_addr[W*i +: W]);
    @(posedge clk);
    @(negedge clk);
    chk("R4 chk_valid", W'(chk_valid), W'(e_vld));
    chk("R5 chk_error", W'(chk_error), W'(e_err));
    chk("R5 chk_sum", chk_sum, e_sum);
    clear_in();
  endtask

  task automatic set_evt(input int i, input logic [1:0] o, input logic [1:0] n,
                         input logic [W-1:0] a);
    evt_vld[i] = 1'b1; evt_old[2*i +: 2] = o; evt_new[2*i +: 2] = n; evt_addr[W*i +: W] = a;
  endtask

  // Tick until just before the closing request.
  task automatic tick_to_last();
    while (mcnt != PERIOD - 1) begin req_tick = 1; step(); end
  endtask

  task automatic close_epoch();
    tick_to_last(); req_tick = 1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) macc[i] = '0;
    e_vld = 0; e_err = 0; e_sum = '0;
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", W'(chk_valid), '0);
    chk("R8 reset error", W'(chk_error), '0);
    chk("R8 reset sum", chk_sum, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2: one-level upgrade balanced by one-level downgrade elsewhere.
    set_evt(0, 2'd0, 2'd1, 16'h1234); set_evt(1, 2'd1, 2'd0, 16'h1234); step();
    close_epoch(); step();
    // R1 R2: none-to-write balanced by two single-level downgraders.
    set_evt(0, 2'd0, 2'd2, 16'h0100); step();
    set_evt(1, 2'd2, 2'd1, 16'h0100); set_evt(2, 2'd1, 2'd0, 16'h0100); step();
    close_epoch();
    // R2: write-to-none weighs two units.
    set_evt(3, 2'd2, 2'd0, 16'h0021); set_evt(2, 2'd0, 2'd2, 16'h0021); step();
    close_epoch();
    // R5: unbalanced epoch flags an error.
    set_evt(0, 2'd0, 2'd1, 16'h0040); step();
    close_epoch();
    // R3: equal and reserved codes ignored.
    set_evt(0, 2'd1, 2'd1, 16'h5555); set_evt(1, 2'd3, 2'd0, 16'h5555);
    set_evt(2, 2'd0, 2'd3, 16'h5555); set_evt(3, 2'd2, 2'd2, 16'h5555); step();
    close_epoch();
    // R6: event in the closing cycle lands in the next epoch.
    tick_to_last(); req_tick = 1; set_evt(1, 2'd0, 2'd1, 16'h0007); step();
    close_epoch();
    // R7: wrap-around sum to zero.
    set_evt(0, 2'd0, 2'd2, 16'hFFFF); set_evt(1, 2'd0, 2'd1, 16'h0002); step();
    close_epoch();

    // Random traffic (R1-style checks via model on every cycle).
    for (int c = 0; c < 1500; c++) begin
      req_tick = ($urandom % 2) == 0;
      for (int i = 0; i < N; i++)
        if (($urandom % 3) == 0)
          set_evt(i, 2'($urandom % 4), 2'($urandom % 4), W'($urandom % 8));
      step();
    end
    close_epoch(); step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule